// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the bus-facing front end of a parallel NOR flash device, running on a system clock. It accepts the host's asynchronous active-low chip enable, output enable and write enable, together with the address bus and the data bus input. It also takes a byte/word mode pin and a digital identifier-mode strobe, which stands in for the high-voltage level on one address pin. Every control passes through a two-flop synchronizer and a stability filter. A level change counts only after it has held for `FILT` clock cycles, so short pulses on the controls never start or end a bus operation.

A read drives the array word, or a fixed identifier code, onto a data bus output with a per-bit output enable. A write captures its address when chip enable and write enable are first both low. It captures its data from the last cycle in which both were still low. When the write ends, the block hands the captured address and data to the command interface as a one-cycle pulse. Standby is flagged while chip enable is high, unless the busy input reports that a program or erase operation is still running.

In byte mode, data pin 15 is an extra address input. It becomes the least significant address bit, and only data bits 7:0 are driven.

Top module: `flash_bus_front`

## Requirements
- R1: With filtered chip enable low, output enable low and write enable high in word mode, `dq_oe` becomes 16'hFFFF, `dq_out` equals `rd_data`, and `rd_addr` equals {1'b0, addr}.
- R2: While filtered output enable is high, `dq_oe` is all zero one cycle later, whatever the other controls are.
- R3: While filtered chip enable is high, `standby` is 1 (when not busy), `dq_oe` is zero and no write is produced.
- R4: A write (chip enable and write enable both low, output enable high) produces exactly one single-cycle `wr_valid` pulse after chip enable or write enable has been released. The data bus is not driven during the write.
- R5: `wr_addr` holds the address present when chip enable and write enable first became both low. Address changes later in the same write are not taken.
- R6: `wr_data` holds the data bus value from the last cycle before chip enable or write enable rose. Data changed together with that rise is not taken.
- R7: In byte mode (`word_mode`=0), the address is {addr, dq_in[15]}, `wr_data` is {8'h00, dq_in[7:0]}, and a read drives only bits 7:0 (`dq_oe`=16'h00FF, bits 15:8 of `dq_out` zero).
- R8: On a read with `id_mode`=1, addr[1:0]=00 returns 16'h0020 and 01 returns 16'h00D5 (`TOP_BOOT`=1) or 16'h00D6 (`TOP_BOOT`=0). Other values return zero. Byte mode returns the same low byte.
- R9: A low pulse on chip enable or write enable shorter than `FILT` clock cycles changes no filtered control and produces no write. A high pulse of that length during a write does not split it.
- R10: While `busy` is 1, `standby` is 0.
- R11: A write during which output enable is seen low at any time produces no `wr_valid`.
- R12: After reset, with all controls high, `dq_oe` is zero, `wr_valid` is 0 and `standby` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | AW | Address bus |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| id_mode | input | 1 | Identifier-mode strobe |
| busy | input | 1 | Program or erase in progress |
| dq_in | input | 16 | Data bus input side (bit 15 is an address bit in byte mode) |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 16 | Per-bit data bus output enable |
| rd_addr | output | AW+1 | Read address to the array |
| rd_data | input | 16 | Array read data |
| wr_valid | output | 1 | One-cycle pulse: captured write ready |
| wr_addr | output | AW+1 | Captured write address |
| wr_data | output | 16 | Captured write data |
| standby | output | 1 | Device in standby |

## Verification
On every cycle, the assertions check the following:
- output enable high or standby always leaves the bus undriven one cycle later;
- byte mode never enables bits 15:8;
- the write pulse lasts one cycle and follows a release;
- busy suppresses standby;
- a filtered control only ever takes a value that the synchronizer has already presented.

Only the bench's scenarios can show the rest. That covers the actual identifier codes, the exact moments at which address and data are captured, the rejection of short pulses, and the dropping of a write that saw output enable low.

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
  parameter int AW       = 18,
  parameter int FILT     = 3,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          word_mode,
  input  logic          id_mode,
  input  logic          busy,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [15:0]   dq_oe,
  output logic [AW:0]   rd_addr,
  input  logic [15:0]   rd_data,
  output logic          wr_valid,
  output logic [AW:0]   wr_addr,
  output logic [15:0]   wr_data,
  output logic          standby
);

  localparam int CW = $clog2(FILT + 1);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? 8'hD5 : 8'hD6;

  logic [2:0] raw, s1, s2, flt;
  assign raw = {we_n, oe_n, ce_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 3'b111;
      s2 <= 3'b111;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar i = 0; i < 3; i++) begin : g_filt
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b1;
      end else if (s2[i] != lvl) begin
        if (cnt == CW'(FILT - 1)) begin
          lvl <= s2[i];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    assign flt[i] = lvl;
  end

  logic ce_f, oe_f, we_f;
  assign ce_f = flt[0];
  assign oe_f = flt[1];
  assign we_f = flt[2];

  logic [AW-1:0] addr_s1, addr_s2;
  logic [15:0]   dq_s1, dq_s2;
  logic          wm_s1, wm_s2, id_s1, id_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_s1 <= '0;
      addr_s2 <= '0;
      dq_s1   <= '0;
      dq_s2   <= '0;
      wm_s1   <= 1'b1;
      wm_s2   <= 1'b1;
      id_s1   <= 1'b0;
      id_s2   <= 1'b0;
    end else begin
      addr_s1 <= addr;
      addr_s2 <= addr_s1;
      dq_s1   <= dq_in;
      dq_s2   <= dq_s1;
      wm_s1   <= word_mode;
      wm_s2   <= wm_s1;
      id_s1   <= id_mode;
      id_s2   <= id_s1;
    end

  logic [AW:0] full_addr;
  assign full_addr = wm_s2 ? {1'b0, addr_s2} : {addr_s2, dq_s2[15]};
  assign rd_addr   = full_addr;

  logic [7:0] id_byte;
  always_comb
    case (addr_s2[1:0])
      2'b00:   id_byte = 8'h20;
      2'b01:   id_byte = DEV_CODE;
      default: id_byte = 8'h00;
    endcase

  logic        rd_go;
  logic [15:0] rd_word;
  assign rd_go   = !ce_f && !oe_f && we_f;
  assign rd_word = id_s2 ? {8'h00, id_byte}
                 : (wm_s2 ? rd_data : {8'h00, rd_data[7:0]});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dq_oe  <= '0;
      dq_out <= '0;
    end else begin
      dq_oe  <= rd_go ? (wm_s2 ? 16'hFFFF : 16'h00FF) : 16'h0000;
      dq_out <= rd_go ? rd_word : 16'h0000;
    end

  logic        both, both_q, wr_ok;
  logic [15:0] dq_hold;
  assign both = !ce_f && !we_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dq_hold <= '0;
    end else if (!s2[0] && !s2[2]) begin
      dq_hold <= wm_s2 ? dq_s2 : {8'h00, dq_s2[7:0]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      both_q   <= 1'b0;
      wr_ok    <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      both_q   <= both;
      wr_valid <= 1'b0;
      if (both && !both_q) begin
        wr_ok   <= oe_f;
        wr_addr <= full_addr;
      end else if (both && !oe_f) begin
        wr_ok <= 1'b0;
      end
      if (!both && both_q) begin
        wr_valid <= wr_ok;
        wr_data  <= dq_hold;
        wr_ok    <= 1'b0;
      end
    end

  assign standby = ce_f && !busy;

endmodule

module flash_bus_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flt_ce,
  input logic        flt_oe,
  input logic        flt_we,
  input logic        ce_s2,
  input logic        we_s2,
  input logic        wm_s2,
  input logic [15:0] dq_oe,
  input logic        wr_valid,
  input logic        standby,
  input logic        busy
);

  AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flt_oe |=> dq_oe == 16'h0000); // R2

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> dq_oe == 16'h0000); // R3

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R4

  AST_WR_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(flt_ce || flt_we)); // R4

  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wm_s2) |-> dq_oe[15:8] == 8'h00); // R7

  AST_CE_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_ce) |-> flt_ce == $past(ce_s2)); // R9

  AST_WE_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_we) |-> flt_we == $past(we_s2)); // R9

  AST_BUSY_NO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !standby); // R10

endmodule

bind flash_bus_front flash_bus_front_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flt_ce   (ce_f),
  .flt_oe   (oe_f),
  .flt_we   (we_f),
  .ce_s2    (s2[0]),
  .we_s2    (s2[2]),
  .wm_s2    (wm_s2),
  .dq_oe    (dq_oe),
  .wr_valid (wr_valid),
  .standby  (standby),
  .busy     (busy)
);

// File: tb/flash_bus_front_tb.sv
module flash_bus_front_tb;
  localparam int AW = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1, oe_n = 1, we_n = 1, word_mode = 1, id_mode = 0, busy = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0, rd_data = '0;
  logic [15:0] dq_out, dq_oe, wr_data;
  logic [AW:0] rd_addr, wr_addr;
  logic wr_valid, standby;

  int checks = 0, fails = 0, wcnt = 0;
  bit done = 0;
  logic [AW:0] last_wa;
  logic [15:0] last_wd;

  always #2 clk = ~clk;

  flash_bus_front #(.AW(AW), .FILT(3), .TOP_BOOT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .word_mode(word_mode), .id_mode(id_mode), .busy(busy),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .standby(standby));

  always @(negedge clk)
    if (rst_n && wr_valid) begin
      wcnt++;
      last_wa = wr_addr;
      last_wd = wr_data;
    end

  // wm id a[1:0] dq15 rd_data exp_out exp_oe exp_rd_addr[2:0]
  localparam logic [55:0] VEC [7] = '{
    {1'b1, 1'b0, 2'd2, 1'b0, 16'hA5C3, 16'hA5C3, 16'hFFFF, 3'b010},
    {1'b0, 1'b0, 2'd2, 1'b1, 16'h12B7, 16'h00B7, 16'h00FF, 3'b101},
    {1'b1, 1'b1, 2'd0, 1'b0, 16'hFFFF, 16'h0020, 16'hFFFF, 3'b000},
    {1'b1, 1'b1, 2'd1, 1'b0, 16'hFFFF, 16'h00D5, 16'hFFFF, 3'b001},
    {1'b0, 1'b1, 2'd0, 1'b0, 16'hFFFF, 16'h0020, 16'h00FF, 3'b000},
    {1'b0, 1'b1, 2'd1, 1'b0, 16'hFFFF, 16'h00D5, 16'h00FF, 3'b010},
    {1'b1, 1'b1, 2'd3, 1'b0, 16'hFFFF, 16'h0000, 16'hFFFF, 3'b011}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    int w0;
    cyc(3);
    rst_n = 1;
    cyc(10);
    chk("R12 dq_oe", dq_oe, 0);
    chk("R12 wr_valid", wr_valid, 0);
    chk("R12 standby", standby, 1);

    for (int k = 0; k < 7; k++) begin
      logic [55:0] v;
      v = VEC[k];
      word_mode = v[55];
      id_mode = v[54];
      addr = {16'h0, v[53:52]};
      dq_in = {v[51], 15'h0};
      rd_data = v[50:35];
      ce_n = 0; oe_n = 0; we_n = 1;
      cyc(10);
      chk(v[54] ? "R8 id out" : (v[55] ? "R1 read out" : "R7 byte out"), dq_out, v[34:19]);
      chk(v[55] ? "R1 oe" : "R7 oe", dq_oe, v[18:3]);
      chk(v[55] ? "R1 rd_addr" : "R7 rd_addr", rd_addr[2:0], v[2:0]);
      oe_n = 1;
      cyc(10);
      chk("R2 oe high", dq_oe, 0);
      ce_n = 1;
      cyc(10);
    end
    id_mode = 0;

    // word write
    w0 = wcnt;
    word_mode = 1; addr = 18'h2A5A5; dq_in = 16'h1234;
    ce_n = 0; we_n = 0; oe_n = 1;
    cyc(10);
    chk("R4 no drive in write", dq_oe, 0);
    addr = 18'h00111;
    cyc(5);
    we_n = 1; dq_in = 16'hBEEF;
    cyc(10);
    ce_n = 1;
    cyc(10);
    chk("R4 one pulse", wcnt - w0, 1);
    chk("R5 addr", last_wa, {1'b0, 18'h2A5A5});
    chk("R6 data", last_wd, 16'h1234);

    // byte write
    w0 = wcnt;
    word_mode = 0; addr = 18'h00155; dq_in = 16'h80C7;
    ce_n = 0; we_n = 0;
    cyc(10);
    ce_n = 1; dq_in = 16'h0011;
    cyc(10);
    we_n = 1;
    cyc(10);
    chk("R7 byte write", wcnt - w0, 1);
    chk("R7 byte addr", last_wa, {18'h00155, 1'b1});
    chk("R7 byte data", last_wd, 16'h00C7);
    word_mode = 1;

    // output enable low during write
    w0 = wcnt;
    ce_n = 0; we_n = 0;
    cyc(10);
    oe_n = 0;
    cyc(10);
    oe_n = 1;
    cyc(10);
    we_n = 1; ce_n = 1;
    cyc(10);
    chk("R11 dropped write", wcnt - w0, 0);

    // short low glitch on both controls
    w0 = wcnt;
    ce_n = 0; we_n = 0;
    cyc(2);
    ce_n = 1; we_n = 1;
    cyc(15);
    chk("R9 low glitch", wcnt - w0, 0);
    chk("R9 standby kept", standby, 1);

    // short high glitch on write enable mid-write
    w0 = wcnt;
    addr = 18'h00042; dq_in = 16'h5A5A;
    ce_n = 0; we_n = 0;
    cyc(10);
    we_n = 1;
    cyc(2);
    we_n = 0;
    cyc(10);
    we_n = 1;
    cyc(10);
    ce_n = 1;
    cyc(10);
    chk("R9 high glitch single write", wcnt - w0, 1);
    chk("R9 glitch data", last_wd, 16'h5A5A);

    // standby and busy
    ce_n = 1; oe_n = 0; we_n = 1;
    cyc(10);
    chk("R3 standby", standby, 1);
    chk("R3 bus off", dq_oe, 0);
    w0 = wcnt;
    we_n = 0;
    cyc(10);
    we_n = 1;
    cyc(10);
    chk("R3 no write", wcnt - w0, 0);
    busy = 1;
    cyc(2);
    chk("R10 busy", standby, 0);
    busy = 0;
    cyc(2);
    chk("R10 release", standby, 1);
    oe_n = 1;
    cyc(5);
    summary();
  end
endmodule